// File: doc/BRIEF.md
# Filtered 4x Quadrature Decoder

This block turns the two phase outputs of an incremental encoder into step events for a position counter. Both raw channels are asynchronous to the clock. Each one first passes through a synchronizer chain and then through a stability filter. The filter takes a new level only after that level has been seen on a fixed number of successive rising edges. A transition decoder then compares the filtered channel pair with its value one cycle earlier. Every move to a neighbouring quadrature phase produces a single-cycle step pulse with a direction bit, so one full encoder cycle gives four steps.

A jump to the opposite phase means both channels changed together. The decoder cannot tell the direction of such a jump, so it raises a single-cycle fault flag and makes no step. The synchronizer depth and the filter length are parameters. An elaboration-time check keeps their combined delay inside a fixed budget measured from an input change to the step pulse.

Top module: `quad_decoder_4x`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `count_en` and `illegal` are 0 and `dir_up` is 1. If the inputs are steady through reset, no step follows the release, whatever the input levels are.
- R2: A raw level change that lasts fewer than 3 clock cycles produces no step and no fault. A change held for 3 cycles or more is accepted.
- R3: The phases are indexed 0..3 as (A,B) = (1,0), (1,1), (0,1), (0,0). A move from index i to index (i+1) mod 4 gives one step with `dir_up` = 1. This is the case where A leads B.
- R4: A move from index i to index (i+3) mod 4 gives one step with `dir_up` = 0. This is the case where B leads A.
- R5: Each accepted neighbouring move gives exactly one pulse, one cycle long. Steps spaced 4 cycles apart are all counted, with no pulse lost or merged.
- R6: With the default parameters, suppose a raw change is set up before rising edge k and then held. `count_en` (or `illegal`) is high only between edges k+5 and k+6. This is within a 7-period budget.
- R7: A move from index i to index (i+2) mod 4, with both channels changing together, gives no step. Instead `illegal` is high for one cycle, at the time a step would have appeared.
- R8: `dir_up` changes only together with a step pulse. Between steps it keeps the direction of the most recent step.
- R9: Steady inputs give no step and no fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| ch_a_raw | input | 1 | Encoder channel A, asynchronous |
| ch_b_raw | input | 1 | Encoder channel B, asynchronous |
| count_en | output | 1 | One-cycle step pulse for the position counter |
| dir_up | output | 1 | Direction of the latest step, 1 = up |
| illegal | output | 1 | One-cycle flag for a two-channel jump |

## Verification
The case hardest to reach from the ports is a raw level that lasts exactly as long as the filter threshold, or one cycle less. That window can only be set with cycle-exact stimulus, applied after the synchronizer has settled. The bench toggles one channel for 1, 2 and 3 cycles from each phase and counts the pulses over a window long enough to cover the full pipeline. The bench also sweeps all sixteen (from, to) phase pairs, checks the exact cycle of every pulse, and runs back-to-back rotations at the minimum legal spacing in both directions.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
   typedef struct packed {
      logic a;
      logic b;
   } qphase_t;

   // forward order index: (1,0)=0 (1,1)=1 (0,1)=2 (0,0)=3
   function automatic logic [1:0] phase_idx(input qphase_t s);
      return {~s.a, ~(s.a ^ s.b)};
   endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("qdec_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [1:0] age;
   logic       armed;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end
   assign armed = (age == 2'd3);

   generate
      if (DEPTH < 1) begin : g_bad
         $error("qdec_filter: DEPTH must be at least 1");
      end else if (DEPTH == 1) begin : g_pass
         always_ff @(posedge clk) dout <= din;
      end else begin : g_hold
         localparam int HW = DEPTH - 1;
         logic [HW-1:0] hist;
         logic          all_one;
         logic          all_zero;

         assign all_one  = &{hist, din};
         assign all_zero = ~(|{hist, din});

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist <= {HW{din}};
               dout <= din;
            end else begin
               hist <= {hist[HW-2+((HW==1)?1:0):0], din} >> ((HW==1) ? 1 : 0);
               if (all_one)       dout <= 1'b1;
               else if (all_zero) dout <= 1'b0;
            end
         end

         // R2
         filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !$stable(dout)) |-> ($past(din) == dout));
         if (DEPTH >= 3) begin : g_deep
            // R2
            filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (armed && !$stable(dout)) |-> ($past(din, 2) == dout));
         end
      end
   endgenerate
endmodule

// File: rtl/qdec_xlate.sv
module qdec_xlate
   import qdec_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  qphase_t cur,
   output logic    count_en,
   output logic    dir_up,
   output logic    illegal
);
   qphase_t    prev;
   logic [1:0] step;
   logic [1:0] age;
   logic       armed;

   assign step = phase_idx(cur) - phase_idx(prev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev     <= cur;
         count_en <= 1'b0;
         dir_up   <= 1'b1;
         illegal  <= 1'b0;
      end else begin
         prev     <= cur;
         count_en <= step[0];
         illegal  <= (step == 2'd2);
         if (step[0]) dir_up <= ~step[1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end
   assign armed = (age == 2'd3);

   // R7
   step_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({count_en, illegal}));
   // R5
   step_needs_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && count_en) |-> ($past(cur) != $past(cur, 2)));
   // R7
   fault_is_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && illegal) |-> ($past(cur) == ~$past(cur, 2)));
   // R3
   up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && count_en && dir_up) |->
         (phase_idx($past(cur)) == phase_idx($past(cur, 2)) + 2'd1));
   // R8
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !count_en) |-> $stable(dir_up));
endmodule

// File: rtl/quad_decoder_4x.sv
module quad_decoder_4x
   import qdec_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int MAX_LATENCY = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ch_a_raw,
   input  logic ch_b_raw,
   output logic count_en,
   output logic dir_up,
   output logic illegal
);
   localparam int PIPE_EDGES = SYNC_STAGES + FILT_LEN + 1;

   generate
      if (PIPE_EDGES > MAX_LATENCY) begin : g_budget
         $error("quad_decoder_4x: sync plus filter exceed latency budget");
      end
   endgenerate

   logic [1:0] raw;
   logic [1:0] synced;
   logic [1:0] clean;
   qphase_t    cur;

   assign raw = {ch_a_raw, ch_b_raw};

   generate
      for (genvar c = 0; c < 2; c++) begin : g_chan
         qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .din  (raw[c]),
            .dout (synced[c])
         );
         qdec_filter #(.DEPTH(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (synced[c]),
            .dout  (clean[c])
         );
      end
   endgenerate

   assign cur.a = clean[1];
   assign cur.b = clean[0];

   qdec_xlate u_xlate (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (cur),
      .count_en (count_en),
      .dir_up   (dir_up),
      .illegal  (illegal)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!count_en && !illegal && dir_up));
endmodule

// File: tb/sim_quad_decoder_4x.sv
module sim_quad_decoder_4x;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ch_a = 1'b1;
   logic ch_b = 1'b1;
   logic count_en, dir_up, illegal;

   int vectors = 0;
   int errors  = 0;
   bit finished = 1'b0;
   int cur_idx = 1;
   bit last_dir = 1'b1;

   always #2 clk = ~clk;

   quad_decoder_4x u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_a_raw (ch_a),
      .ch_b_raw (ch_b),
      .count_en (count_en),
      .dir_up   (dir_up),
      .illegal  (illegal)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic drive_idx(input int idx);
      bit a, lo;
      a  = ~idx[1];
      lo = idx[0];
      ch_a = a;
      ch_b = a ^ ~lo;
   endtask

   // apply a phase at a negedge; pulse expected exactly 6 negedges later (R6)
   task automatic step_to(input int t);
      int  diff;
      bit  e_cnt, e_ill, e_dir;
      diff  = (t - cur_idx) & 3;
      e_cnt = (diff == 1) || (diff == 3);
      e_ill = (diff == 2);
      e_dir = (diff == 1) ? 1'b1 : (diff == 3) ? 1'b0 : last_dir;
      @(negedge clk);
      drive_idx(t);
      for (int n = 1; n <= 8; n++) begin
         @(negedge clk);
         // R6 R3 R4 R9
         chk(count_en == ((n == 6) && e_cnt), "R6 count_en timing", count_en, (n == 6) && e_cnt);
         // R7
         chk(illegal == ((n == 6) && e_ill), "R7 illegal timing", illegal, (n == 6) && e_ill);
         // R8 R3 R4
         chk(dir_up == ((n >= 6) ? e_dir : last_dir), "R8 dir_up", dir_up, (n >= 6) ? e_dir : last_dir);
      end
      cur_idx  = t;
      last_dir = e_dir;
   endtask

   // toggle channel A for len cycles, then restore (R2)
   task automatic glitch_a(input int len);
      int pulses, faults, g_idx, back;
      pulses = 0;
      faults = 0;
      g_idx = (cur_idx[1] == 1'b0) ? ((cur_idx[0]) ? 2 : 3) : ((cur_idx[0]) ? 0 : 1);
      @(negedge clk);
      ch_a = ~ch_a;
      for (int n = 0; n < len + 14; n++) begin
         @(negedge clk);
         if (n == len - 1) ch_a = ~ch_a;
         if (count_en) pulses++;
         if (illegal)  faults++;
      end
      // R2
      chk(pulses == ((len >= 3) ? 2 : 0), "R2 glitch steps", pulses, (len >= 3) ? 2 : 0);
      chk(faults == 0, "R2 glitch faults", faults, 0);
      if (len >= 3) begin
         back = (cur_idx - g_idx) & 3;
         last_dir = (back == 1);
      end
      chk(dir_up == last_dir, "R8 dir after glitch", dir_up, last_dir);
   endtask

   task automatic rotate(input bit fwd);
      int pulses, k;
      bit prev_p;
      pulses = 0;
      k = 0;
      prev_p = 1'b0;
      for (int cyc = 0; cyc < 12 * 4 + 12; cyc++) begin
         @(negedge clk);
         if (count_en) begin
            pulses++;
            // R3 R4
            chk(dir_up == fwd, "R3/R4 rotation dir", dir_up, fwd);
         end
         // R5
         chk(!(count_en && prev_p), "R5 pulse width", count_en, 0);
         chk(!illegal, "R5 no fault in rotation", illegal, 0);
         prev_p = count_en;
         if ((cyc % 4 == 0) && (k < 12)) begin
            cur_idx = fwd ? ((cur_idx + 1) & 3) : ((cur_idx + 3) & 3);
            drive_idx(cur_idx);
            k++;
         end
      end
      // R5
      chk(pulses == 12, "R5 rotation step count", pulses, 12);
      last_dir = fwd;
   endtask

   initial begin
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         // R1
         if (n >= 1) begin
            chk(!count_en, "R1 reset count_en", count_en, 0);
            chk(!illegal, "R1 reset illegal", illegal, 0);
            chk(dir_up, "R1 reset dir_up", dir_up, 1);
         end
      end
      rst_n = 1'b1;
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         // R1 R9
         chk(!count_en && !illegal, "R1/R9 quiet after reset", count_en + 2 * illegal, 0);
         chk(dir_up, "R1 dir after reset", dir_up, 1);
      end
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < 4; t++) begin
            step_to(s);
            step_to(t);
         end
      for (int s = 0; s < 4; s++) begin
         step_to(s);
         glitch_a(1);
         glitch_a(2);
         glitch_a(3);
      end
      rotate(1'b1);
      rotate(1'b0);
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         // R9 R8
         chk(!count_en && !illegal, "R9 idle", count_en + 2 * illegal, 0);
         chk(dir_up == last_dir, "R8 idle dir", dir_up, last_dir);
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule